// File: doc/BRIEF.md
# In-Order Retirement Buffer with Committed Register Map

This block keeps a circular window of in-flight instructions. Instructions enter at the young end in program order, one per accepted allocation, and each one is given a slot number as its tag. Execution units later report completion for any tag in any order. A completion only marks that slot as finished. It may also carry a mispredict flag when the slot holds a branch.

The block retires at most one instruction per cycle, and always from the old end. It retires a slot only once that slot is finished. A finished slot that sits behind an unfinished older slot waits. When an instruction that writes a register retires, the committed table entry for its architectural register is set to its physical register. When a branch that was flagged as mispredicted retires, every younger slot is dropped, finished or not, and a one-cycle flush pulse is raised. The committed table can be read at any time through a combinational port.

Allocation uses a valid/ready handshake. A slot is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` falls when all slots are in use, or during a flush cycle. The source must hold its request until it is accepted. Completion and retirement are plain strobes with no back-pressure. A completion is always taken. A retirement is announced in the cycle it takes effect, and the consumer cannot stall it.

Top module: `rob_retire_map`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `ret_valid` and `flush` are 0, and committed map entry i reads physical register i for every architectural register.
- R2: Accepted allocations receive tags that start at 0 after reset and increase by 1 modulo 16 per accepted allocation; `alloc_tag` shows the tag the next accepted allocation will receive.
- R3: With 16 slots in use, `alloc_ready` is 0, and a request held in that state takes no slot: exactly 16 retirements follow once all are completed.
- R4: A completion only marks its slot finished; nothing retires while the oldest slot is unfinished, even when younger slots are finished.
- R5: `ret_valid` is high in a cycle exactly when the buffer is non-empty and the oldest slot is finished; then `ret_tag` is that slot's tag, that slot leaves the buffer at the next clock edge, and retirements come in tag order, one per cycle at most.
- R6: A retiring slot that has a destination writes its physical register into the committed map entry of its architectural register, and this is visible on the read port from the cycle after `ret_valid`; before retirement the map is unchanged, and a later retirement to the same architectural register overrides an earlier one.
- R7: A retiring slot with no destination (a branch, or `alloc_has_dst` = 0) leaves the committed map unchanged, whatever architectural and physical values were given at allocation.
- R8: When a branch flagged as mispredicted retires, `flush` is 1 in the same cycle as its `ret_valid`, `alloc_ready` is 0 in that cycle, and all younger slots are discarded without updating the map; the buffer is empty the next cycle, and the next allocation receives the tag after the branch's tag.
- R9: A branch completed with the mispredict flag at 0 retires without `flush`, and younger slots retire normally after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A slot is free and no flush is in progress |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_is_branch | input | 1 | Instruction is a branch (never writes a register) |
| alloc_arch_dst | input | 3 | Architectural destination index |
| alloc_phys_dst | input | 5 | Physical destination index |
| alloc_tag | output | 4 | Tag given to the next accepted allocation |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 4 | Tag of the completed instruction |
| cmp_mispredict | input | 1 | Branch resolved as mispredicted |
| ret_valid | output | 1 | Oldest slot retires at the coming clock edge |
| ret_has_dst | output | 1 | Retiring slot updates the committed map |
| ret_arch_dst | output | 3 | Architectural destination of the retiring slot |
| ret_phys_dst | output | 5 | Physical destination of the retiring slot |
| ret_tag | output | 4 | Tag of the retiring slot |
| flush | output | 1 | Mispredicted branch retiring; younger slots dropped |
| map_rd_idx | input | 3 | Committed map read address |
| map_rd_phys | output | 5 | Committed physical register for `map_rd_idx` |

## Verification
Four completion orders are applied. In the first, completions arrive in reverse order behind an unfinished head. This tells in-order retirement apart from retiring whatever is ready. In the second, every slot is filled and then completed youngest first. This separates correct full detection from off-by-one occupancy, and shows whether a refused request leaks into a slot. In the third, younger slots are finished before a mispredicted branch at the head. This separates a real squash from one that lets finished work through. In the fourth, a correctly predicted branch and a slot with a destination of no effect show that only true register writers touch the committed map.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  // What the oldest slot does in the current cycle
  typedef enum logic [1:0] {
    RET_IDLE   = 2'd0,
    RET_COMMIT = 2'd1,
    RET_DROP   = 2'd2,
    RET_FLUSH  = 2'd3
  } ret_act_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
`timescale 1ns/1ps
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             squash,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (squash) begin
      // the branch at the head leaves; all younger slots are gone
      head  <= head + 1'b1;
      tail  <= head + 1'b1;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rob_entry_store.sv
`timescale 1ns/1ps
module rob_entry_store #(
  parameter int DEPTH  = 16,
  parameter int ARCH_W = 3,
  parameter int PHYS_W = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic              alloc_dst,
  input  logic              alloc_br,
  input  logic [ARCH_W-1:0] alloc_arch,
  input  logic [PHYS_W-1:0] alloc_phys,
  input  logic              cmp_we,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic              cmp_bad,
  input  logic              pop,
  input  logic              squash,
  input  logic [IDX_W-1:0]  head_idx,
  output logic              head_done,
  output logic              head_bad,
  output logic              head_dst,
  output logic [ARCH_W-1:0] head_arch,
  output logic [PHYS_W-1:0] head_phys
);
  logic [DEPTH-1:0]  live_v, done_v, bad_v, dst_v;
  logic [ARCH_W-1:0] arch_a [DEPTH];
  logic [PHYS_W-1:0] phys_a [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(e);
    logic              live_q, done_q, bad_q, dst_q, br_q;
    logic [ARCH_W-1:0] arch_q;
    logic [PHYS_W-1:0] phys_q;
    logic              take, finish, leave;

    assign take   = alloc_we && (alloc_idx == SLOT);
    assign finish = cmp_we && (cmp_idx == SLOT) && live_q;
    assign leave  = pop && (head_idx == SLOT);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q <= 1'b0;
        done_q <= 1'b0;
        bad_q  <= 1'b0;
        dst_q  <= 1'b0;
        br_q   <= 1'b0;
        arch_q <= '0;
        phys_q <= '0;
      end else if (squash) begin
        live_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (leave) live_q <= 1'b0;
        if (take) begin
          live_q <= 1'b1;
          done_q <= 1'b0;
          bad_q  <= 1'b0;
          br_q   <= alloc_br;
          dst_q  <= alloc_dst && !alloc_br;
          arch_q <= alloc_arch;
          phys_q <= alloc_phys;
        end
        if (finish) begin
          done_q <= 1'b1;
          bad_q  <= cmp_bad && br_q;
        end
      end
    end

    assign live_v[e] = live_q;
    assign done_v[e] = done_q;
    assign bad_v[e]  = bad_q;
    assign dst_v[e]  = dst_q;
    assign arch_a[e] = arch_q;
    assign phys_a[e] = phys_q;
  end

  assign head_done = live_v[head_idx] && done_v[head_idx];
  assign head_bad  = bad_v[head_idx];
  assign head_dst  = dst_v[head_idx];
  assign head_arch = arch_a[head_idx];
  assign head_phys = phys_a[head_idx];
endmodule

// File: rtl/rob_commit_map.sv
`timescale 1ns/1ps
module rob_commit_map #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 32,
  localparam int ARCH_W = $clog2(ARCH_REGS),
  localparam int PHYS_W = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_arch,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [ARCH_W-1:0] rd_arch,
  output logic [PHYS_W-1:0] rd_phys
);
  logic [PHYS_W-1:0] map_a [ARCH_REGS];

  for (genvar a = 0; a < ARCH_REGS; a++) begin : g_map
    localparam logic [ARCH_W-1:0] AIDX = ARCH_W'(a);
    logic [PHYS_W-1:0] phys_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            phys_q <= PHYS_W'(a);
      else if (wr_en && (wr_arch == AIDX))   phys_q <= wr_phys;
    end
    assign map_a[a] = phys_q;
  end

  assign rd_phys = map_a[rd_arch];
endmodule

// File: rtl/rob_retire_map.sv
`timescale 1ns/1ps
module rob_retire_map #(
  parameter int DEPTH     = 16,
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 32,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ARCH_W = $clog2(ARCH_REGS),
  localparam int PHYS_W = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              alloc_has_dst,
  input  logic              alloc_is_branch,
  input  logic [ARCH_W-1:0] alloc_arch_dst,
  input  logic [PHYS_W-1:0] alloc_phys_dst,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic              cmp_mispredict,
  output logic              ret_valid,
  output logic              ret_has_dst,
  output logic [ARCH_W-1:0] ret_arch_dst,
  output logic [PHYS_W-1:0] ret_phys_dst,
  output logic [TAG_W-1:0]  ret_tag,
  output logic              flush,
  input  logic [ARCH_W-1:0] map_rd_idx,
  output logic [PHYS_W-1:0] map_rd_phys
);
  import rob_pkg::*;

  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              head_done, head_bad, head_dst;
  logic [ARCH_W-1:0] head_arch;
  logic [PHYS_W-1:0] head_phys;
  logic              push, pop;
  ret_act_e          act;

  always_comb begin
    act = RET_IDLE;
    if ((count != '0) && head_done) begin
      if (head_bad)      act = RET_FLUSH;
      else if (head_dst) act = RET_COMMIT;
      else               act = RET_DROP;
    end
  end

  assign ret_valid    = (act != RET_IDLE);
  assign flush        = (act == RET_FLUSH);
  assign ret_has_dst  = (act == RET_COMMIT);
  assign ret_arch_dst = head_arch;
  assign ret_phys_dst = head_phys;
  assign ret_tag      = head;
  assign alloc_ready  = (count != CNT_W'(DEPTH)) && !flush;
  assign alloc_tag    = tail;
  assign push         = alloc_valid && alloc_ready;
  assign pop          = ret_valid && !flush;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .squash (flush),
    .head   (head),
    .tail   (tail),
    .count  (count)
  );

  rob_entry_store #(.DEPTH(DEPTH), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_we   (push),
    .alloc_idx  (tail),
    .alloc_dst  (alloc_has_dst),
    .alloc_br   (alloc_is_branch),
    .alloc_arch (alloc_arch_dst),
    .alloc_phys (alloc_phys_dst),
    .cmp_we     (cmp_valid),
    .cmp_idx    (cmp_tag),
    .cmp_bad    (cmp_mispredict),
    .pop        (pop),
    .squash     (flush),
    .head_idx   (head),
    .head_done  (head_done),
    .head_bad   (head_bad),
    .head_dst   (head_dst),
    .head_arch  (head_arch),
    .head_phys  (head_phys)
  );

  rob_commit_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (act == RET_COMMIT),
    .wr_arch (head_arch),
    .wr_phys (head_phys),
    .rd_arch (map_rd_idx),
    .rd_phys (map_rd_phys)
  );
endmodule

// File: rtl/rob_retire_map_chk.sv
`timescale 1ns/1ps
module rob_retire_map_chk #(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             ret_valid,
  input logic [TAG_W-1:0] ret_tag,
  input logic             flush
);
  logic [OCC_W-1:0] occ;
  logic             took;

  assign took = alloc_valid && alloc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)     occ <= '0;
    else if (flush) occ <= '0;
    else begin
      case ({took, ret_valid})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: ;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) |-> !alloc_ready); // R3
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !ret_valid); // R5
  AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && $past(ret_valid && !flush)) |-> (ret_tag == TAG_W'($past(ret_tag) + 1'b1))); // R5
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ready && $past(took)) |-> (alloc_tag == TAG_W'($past(alloc_tag) + 1'b1))); // R2
  AST_FLUSH_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_valid && !alloc_ready)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!flush && !ret_valid)); // R8
endmodule

bind rob_retire_map rob_retire_map_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_tag   (alloc_tag),
  .ret_valid   (ret_valid),
  .ret_tag     (ret_tag),
  .flush       (flush)
);

// File: tb/test_rob_retire_map.sv
`timescale 1ns/1ps
module test_rob_retire_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0, alloc_ready;
  logic       alloc_has_dst = 1'b0, alloc_is_branch = 1'b0;
  logic [2:0] alloc_arch_dst = '0;
  logic [4:0] alloc_phys_dst = '0;
  logic [3:0] alloc_tag;
  logic       cmp_valid = 1'b0, cmp_mispredict = 1'b0;
  logic [3:0] cmp_tag = '0;
  logic       ret_valid, ret_has_dst, flush;
  logic [2:0] ret_arch_dst;
  logic [4:0] ret_phys_dst;
  logic [3:0] ret_tag;
  logic [2:0] map_rd_idx = '0;
  logic [4:0] map_rd_phys;

  int n_chk = 0, n_err = 0, n_ret = 0, n_flush = 0;
  logic       got_ready;
  logic [3:0] got_tag;

  always #2 clk = ~clk;

  rob_retire_map i_rob_retire_map (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_has_dst(alloc_has_dst), .alloc_is_branch(alloc_is_branch),
    .alloc_arch_dst(alloc_arch_dst), .alloc_phys_dst(alloc_phys_dst),
    .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_mispredict(cmp_mispredict),
    .ret_valid(ret_valid), .ret_has_dst(ret_has_dst),
    .ret_arch_dst(ret_arch_dst), .ret_phys_dst(ret_phys_dst),
    .ret_tag(ret_tag), .flush(flush),
    .map_rd_idx(map_rd_idx), .map_rd_phys(map_rd_phys)
  );

  always @(posedge clk) begin
    if (rst_n && ret_valid) n_ret++;
    if (rst_n && flush)     n_flush++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_map(input string req, input int idx, input int exp);
    map_rd_idx = 3'(idx);
    #1;
    chk(req, $sformatf("map[%0d]", idx), int'(map_rd_phys), exp);
  endtask

  task automatic do_alloc(input bit dst, input bit br, input int arch, input int phys);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_has_dst = dst; alloc_is_branch = br;
    alloc_arch_dst = 3'(arch); alloc_phys_dst = 5'(phys);
    #1;
    got_ready = alloc_ready;
    got_tag   = alloc_tag;
  endtask

  task automatic alloc_stop();
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_cmp(input int tag, input bit bad);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_tag = 4'(tag); cmp_mispredict = bad;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_mispredict = 1'b0;
  endtask

  // step: {cmp_valid, cmp_tag[3:0], exp_ret_valid, exp_ret_tag[3:0], exp_map1[4:0]}
  localparam int NSTEP = 8;
  localparam logic [14:0] STEPS [NSTEP] = '{
    {1'b1, 4'd2, 1'b0, 4'd0, 5'd1},
    {1'b1, 4'd1, 1'b0, 4'd0, 5'd1},
    {1'b1, 4'd0, 1'b1, 4'd0, 5'd1},
    {1'b0, 4'd0, 1'b1, 4'd1, 5'd10},
    {1'b0, 4'd0, 1'b1, 4'd2, 5'd10},
    {1'b0, 4'd0, 1'b0, 4'd0, 5'd10},
    {1'b1, 4'd3, 1'b1, 4'd3, 5'd10},
    {1'b0, 4'd0, 1'b0, 4'd0, 5'd12}
  };

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int base_ret, base_fl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "alloc_ready", int'(alloc_ready), 1);
    chk("R1", "ret_valid", int'(ret_valid), 0);
    chk("R1", "flush", int'(flush), 0);
    chk("R2", "first tag", int'(alloc_tag), 0);
    for (int i = 0; i < 8; i++) chk_map("R1", i, i);

    // four slots: a1->p10, a2->p11, no-dst a5->p20, a1->p12
    do_alloc(1, 0, 1, 10); chk("R2", "tag", int'(got_tag), 0);
    do_alloc(1, 0, 2, 11); chk("R2", "tag", int'(got_tag), 1);
    do_alloc(0, 0, 5, 20); chk("R2", "tag", int'(got_tag), 2);
    do_alloc(1, 0, 1, 12); chk("R2", "tag", int'(got_tag), 3);
    alloc_stop();

    // R4 R5 R6 table walk
    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      cmp_valid = STEPS[s][14]; cmp_tag = STEPS[s][13:10]; cmp_mispredict = 1'b0;
      map_rd_idx = 3'd1;
      @(posedge clk);
      #1;
      chk("R4", $sformatf("step %0d ret_valid", s), int'(ret_valid), int'(STEPS[s][9]));
      if (STEPS[s][9]) chk("R5", $sformatf("step %0d ret_tag", s), int'(ret_tag), int'(STEPS[s][8:5]));
      chk("R6", $sformatf("step %0d map[1]", s), int'(map_rd_phys), int'(STEPS[s][4:0]));
    end
    @(negedge clk);
    cmp_valid = 1'b0;
    chk_map("R6", 2, 11);
    chk_map("R7", 5, 5);
    chk_map("R6", 0, 0);

    // R3 fill all 16 slots, tags continue from 4
    for (int k = 0; k < 16; k++) begin
      do_alloc(1, 0, 3, 16 + k);
      chk("R3", "ready while filling", int'(got_ready), 1);
      chk("R2", "wrapped tag", int'(got_tag), (4 + k) % 16);
    end
    do_alloc(1, 0, 4, 30);
    chk("R3", "ready when full", int'(got_ready), 0);
    repeat (3) @(negedge clk);
    alloc_stop();
    base_ret = n_ret;
    // complete youngest first; head (tag 4) last
    for (int k = 15; k >= 1; k--) do_cmp((4 + k) % 16, 1'b0);
    chk("R4", "no retire before head done", n_ret - base_ret, 0);
    do_cmp(4, 1'b0);
    repeat (20) @(negedge clk);
    chk("R3", "retired after fill", n_ret - base_ret, 16);
    chk_map("R6", 3, 31);
    chk_map("R3", 4, 4);

    // R8 mispredicted branch at tag 4 with finished younger slots
    do_alloc(0, 1, 0, 0);  chk("R2", "branch tag", int'(got_tag), 4);
    do_alloc(1, 0, 6, 25); chk("R2", "tag", int'(got_tag), 5);
    do_alloc(1, 0, 7, 26); chk("R2", "tag", int'(got_tag), 6);
    alloc_stop();
    do_cmp(5, 1'b0);
    do_cmp(6, 1'b0);
    #1;
    chk("R4", "younger done, head not", int'(ret_valid), 0);
    base_ret = n_ret; base_fl = n_flush;
    do_cmp(4, 1'b1);
    chk("R8", "ret_valid at flush", int'(ret_valid), 1);
    chk("R8", "flush", int'(flush), 1);
    chk("R8", "ret_tag", int'(ret_tag), 4);
    chk("R8", "alloc_ready at flush", int'(alloc_ready), 0);
    @(posedge clk);
    #1;
    chk("R8", "flush after", int'(flush), 0);
    chk("R8", "ret_valid after", int'(ret_valid), 0);
    chk("R8", "alloc_ready after", int'(alloc_ready), 1);
    repeat (3) @(negedge clk);
    chk("R8", "retired count", n_ret - base_ret, 1);
    chk_map("R8", 6, 6);
    chk_map("R8", 7, 7);

    // R9 correctly predicted branch, then a writer
    do_alloc(0, 1, 0, 0);  chk("R8", "tag after flush", int'(got_tag), 5);
    do_alloc(1, 0, 6, 27); chk("R2", "tag", int'(got_tag), 6);
    alloc_stop();
    base_ret = n_ret;
    do_cmp(6, 1'b0);
    do_cmp(5, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9", "retired count", n_ret - base_ret, 2);
    chk("R9", "no flush", n_flush - base_fl, 1);
    chk_map("R9", 6, 27);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule